// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends 8-bit characters on a single serial line. A bus master writes each character into a one-entry holding register. When the shift register is free, the block moves the held character into it, and then sends a frame on `txd_o`. A frame is one low start bit, the data bits with the least significant bit first, an optional even-parity bit and one high stop bit. Each bit lasts `BAUD_DIV` clock cycles, and the line stays high between frames.

Software polls `trdy_o` to learn when the holding register can accept the next character. The flag drops for every accepted write. It rises again when the held character moves into the shift register. If the shifter is idle, this takes one cycle. If the shifter is busy, it happens on the same edge where the current frame's stop bit ends. The next frame then follows with no idle gap. `tmt_o` shows that both registers are empty. A small register port lets software read the two flags and the write-only data location.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset, `txd_o` is 1, `trdy_o` is 1, `tmt_o` is 1 and `rdata_o` is 0.
- R2: A write to address 0 while `trdy_o` is 1 drives `trdy_o` to 0 in the cycle after the write edge.
- R3: If the shifter is idle, the written character moves to the shifter on the next edge. `trdy_o` is then 1 again, and `txd_o` shows the start bit (0) one cycle after the write edge.
- R4: Each frame is, in time order: start bit 0, data bits 0 to 7 (least significant first), and an even-parity bit when `PARITY_EN` is 1. The parity bit is the XOR of the 8 data bits. The frame ends with stop bit 1. Every bit lasts exactly `BAUD_DIV` cycles.
- R5: A character written while a frame is in flight is held. `trdy_o` stays 0 until the edge that ends the current stop bit. On that same edge the held frame's start bit begins, with no idle cycle in between. If the first character was written at edge W, `trdy_o` is 1 again after edge W+1+N*`BAUD_DIV`, where N is the number of bits per frame.
- R6: A write to address 0 while `trdy_o` is 0 is ignored. The held character is sent unchanged, and no extra frame follows.
- R7: A read of address 0 returns 0 on `rdata_o` one cycle after the read edge.
- R8: A read of address 1 returns the status one cycle after the read edge: bit 0 is `trdy_o`, bit 1 is `tmt_o`, and the other bits are 0.
- R9: `tmt_o` is 1 only when neither the holding register nor the shifter holds a character.
- R10: `txd_o` is 1 whenever no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register select: 0 = data, 1 = status |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| trdy_o | output | 1 | Holding register can accept a character |
| tmt_o | output | 1 | Holding register and shifter both empty |
| txd_o | output | 1 | Serial output, idles high |

## Verification
The two functions that can fall in one cycle are the end of a frame's stop bit and the handoff of the held character into the shifter. The bench provokes this by writing a second character while the first is still being shifted out. It then adds an ignored third write and a status read while the holding register is full. It judges the result on two counts. First, `trdy_o` must rise in exactly the cycle computed from the first write edge. Second, the scoreboard monitor must decode both frames, with the second start bit directly after the first stop bit, and must receive no frame for the ignored byte.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic {
    REG_DATA = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;

  function automatic int frame_bits(int dw, bit par);
    return dw + 2 + (par ? 1 : 0);
  endfunction
endpackage

// File: rtl/tx_baud.sv
module tx_baud #(
  parameter int BAUD_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(BAUD_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= RELOAD;
    else if (run_i) begin
      if (cnt_q == '0)          cnt_q <= RELOAD;
      else                      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == '0);

  // R4: bit period counter never leaves its range
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RELOAD);
  // R4: restart always yields a full period before the next tick
  a_r4_restart_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == RELOAD));
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              shift_ready_i,
  output logic              valid_o,
  output logic              load_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign load_o  = valid_q && shift_ready_i;
  assign valid_o = valid_q;
  assign data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (!valid_q) begin
      if (wr_i) begin
        valid_q <= 1'b1;
        data_q  <= wdata_i;
      end
    end else if (load_o) begin
      valid_q <= 1'b0;
    end
    // write while full is dropped
  end

  // R6: held character cannot change until it is handed off
  a_r6_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !load_o) |=> (valid_q && $stable(data_q)));
  // R3: handoff empties the holding register
  a_r3_handoff_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !valid_q);
endmodule

// File: rtl/tx_shift.sv
module tx_shift #(
  parameter int DATA_W    = 8,
  parameter int BAUD_DIV  = 16,
  parameter bit PARITY_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic              txd_o
);
  import uart_tx_pkg::*;

  localparam int NB = frame_bits(DATA_W, PARITY_EN);
  localparam int BW = $clog2(NB);

  logic [NB-1:0] frame;
  logic [NB-1:0] shreg_q;
  logic [BW-1:0] bcnt_q;
  logic          busy_q;
  logic          tick;
  logic          last;

  generate
    if (PARITY_EN) begin : g_par
      assign frame = {1'b1, ^data_i, data_i, 1'b0};
    end else begin : g_nopar
      assign frame = {1'b1, data_i, 1'b0};
    end
  endgenerate

  tx_baud #(.BAUD_DIV(BAUD_DIV)) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_i),
    .run_i     (busy_q),
    .tick_o    (tick)
  );

  assign last    = busy_q && tick && (bcnt_q == '0);
  assign ready_o = !busy_q || last;
  assign busy_o  = busy_q;
  assign txd_o   = busy_q ? shreg_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      bcnt_q  <= '0;
      busy_q  <= 1'b0;
    end else if (load_i) begin
      shreg_q <= frame;
      bcnt_q  <= BW'(NB - 1);
      busy_q  <= 1'b1;
    end else if (busy_q && tick) begin
      if (bcnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        shreg_q <= {1'b1, shreg_q[NB-1:1]};
        bcnt_q  <= bcnt_q - 1'b1;
      end
    end
  end

  // R10: line high whenever idle
  a_r10_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> txd_o);
  // R4: a load starts a frame with a low start bit
  a_r4_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (busy_q && !txd_o));
  // R5: shifter only accepts at idle or at the final bit edge
  a_r5_load_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |-> !load_i);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W    = 8,
  parameter int BAUD_DIV  = 16,
  parameter bit PARITY_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              trdy_o,
  output logic              tmt_o,
  output logic              txd_o
);
  import uart_tx_pkg::*;

  logic              hold_valid;
  logic              load;
  logic [DATA_W-1:0] hold_data;
  logic              sh_busy;
  logic              sh_ready;
  logic              data_wr;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] rdata_q;

  assign data_wr = wr_en_i && (reg_sel_e'(addr_i) == REG_DATA);

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (data_wr),
    .wdata_i       (wdata_i),
    .shift_ready_i (sh_ready),
    .valid_o       (hold_valid),
    .load_o        (load),
    .data_o        (hold_data)
  );

  tx_shift #(.DATA_W(DATA_W), .BAUD_DIV(BAUD_DIV), .PARITY_EN(PARITY_EN)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .data_i  (hold_data),
    .busy_o  (sh_busy),
    .ready_o (sh_ready),
    .txd_o   (txd_o)
  );

  assign trdy_o = !hold_valid;
  assign tmt_o  = !hold_valid && !sh_busy;
  assign status = {{(DATA_W-2){1'b0}}, tmt_o, trdy_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          rdata_q <= '0;
    else if (rd_en_i && reg_sel_e'(addr_i) == REG_STAT)   rdata_q <= status;
    else                                                  rdata_q <= '0;
  end
  assign rdata_o = rdata_q;

  // R2: accepted write drops trdy
  a_r2_trdy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && trdy_o) |=> !trdy_o);
  // R7: data location reads as zero
  a_r7_data_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !addr_i) |=> (rdata_o == '0));
  // R9: empty flag implies both stages idle
  a_r9_tmt_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmt_o |-> (trdy_o && txd_o));
endmodule

// File: tb/sim_uart_tx_hold.sv
module sim_uart_tx_hold;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int DIV   = 6;
  localparam int NB    = DW + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr = 1'b0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          trdy, tmt, txd;

  int checks = 0;
  int fails  = 0;
  int frames = 0;
  int cyc    = 0;
  logic [DW-1:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_hold #(.DATA_W(DW), .BAUD_DIV(DIV), .PARITY_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .trdy_o(trdy), .tmt_o(tmt), .txd_o(txd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [DW-1:0] b);
    @(negedge clk); addr = 1'b0; wr = 1'b1; wdata = b;
    @(negedge clk); wr = 1'b0;
  endtask

  // driver: waits for room, writes, pushes expectation
  task automatic send(input logic [DW-1:0] b);
    while (!trdy) @(negedge clk);
    exp_q.push_back(b);
    wr_raw(b);
  endtask

  task automatic rd_reg(input logic a, input int exp, input string req);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk(rdata == DW'(exp), req, rdata, exp);
  endtask

  // monitor: decodes frames mid-bit and compares against the queue
  initial begin
    forever begin
      logic [DW-1:0] got;
      logic par, stp, st;
      @(negedge txd);
      if (!rst_n) continue;
      @(negedge clk);
      repeat (DIV/2) @(negedge clk);
      st = txd;
      for (int i = 0; i < DW; i++) begin
        repeat (DIV) @(negedge clk);
        got[i] = txd;
      end
      repeat (DIV) @(negedge clk); par = txd;
      repeat (DIV) @(negedge clk); stp = txd;
      frames++;
      chk(st == 1'b0, "R4 start bit", st, 0);
      chk(stp == 1'b1, "R4 stop bit", stp, 1);
      chk(par == ^got, "R4 even parity", par, ^got);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected frame", got, 0);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(got == e, "R4 data LSB first", got, e);
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ca;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(trdy == 1'b1, "R1 trdy", trdy, 1);
    chk(tmt == 1'b1, "R1 tmt", tmt, 1);
    chk(rdata == '0, "R1 rdata", rdata, 0);

    // R2/R3: single write into idle shifter
    @(negedge clk);
    ca = cyc;
    exp_q.push_back(8'hA5);
    addr = 1'b0; wr = 1'b1; wdata = 8'hA5;
    @(negedge clk); wr = 1'b0;
    chk(trdy == 1'b0, "R2 trdy drop", trdy, 0);
    chk(tmt == 1'b0, "R9 tmt with held char", tmt, 0);
    @(negedge clk);
    chk(trdy == 1'b1, "R3 trdy back", trdy, 1);
    chk(txd == 1'b0, "R3 start bit", txd, 0);
    chk(tmt == 1'b0, "R9 tmt while shifting", tmt, 0);
    rd_reg(1'b1, 1, "R8 status shifting");

    // R5/R6: second write while busy, then an ignored write
    exp_q.push_back(8'h3C);
    wr_raw(8'h3C);
    chk(trdy == 1'b0, "R5 trdy held low", trdy, 0);
    rd_reg(1'b1, 0, "R8 status held");
    wr_raw(8'hFF);
    rd_reg(1'b0, 0, "R7 data read zero");
    while (!trdy) @(negedge clk);
    chk(cyc == ca + 2 + NB*DIV, "R5 trdy rise cycle", cyc, ca + 2 + NB*DIV);
    chk(txd == 1'b0, "R5 no gap start", txd, 0);

    // stream several patterns
    while (!tmt) @(negedge clk);
    send(8'h00); send(8'hFF); send(8'h01); send(8'h80); send(8'h5A);
    rd_reg(1'b0, 0, "R7 data read zero busy");
    while (!tmt) @(negedge clk);
    repeat (2*DIV*NB) @(negedge clk);
    chk(txd == 1'b1, "R10 idle high", txd, 1);
    rd_reg(1'b1, 3, "R8 status idle");
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
    chk(frames == 7, "R6 frame count", frames, 7);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule